// File: doc/BRIEF.md
# Page Write Buffer and Commit

This block gathers the data bytes of one write sequence into a page-sized staging buffer, then moves the whole page into a backing byte array when the sequence ends. A bus front-end drives it with three kinds of input. A load strobe carries the word address. A valid/ready byte stream carries the data. A stop strobe marks the end of the sequence. The low bits of the address select a byte inside the page, and the upper bits select the page.

When an address is loaded, the block copies the current contents of the addressed page into the buffer. It holds `wr_ready` low while the copy runs. Incoming bytes then overwrite buffer entries starting at the in-page pointer, and the pointer wraps inside the page. A stop that follows at least one byte starts an internal write cycle. During that cycle the buffered page is copied into the array and `busy` is held high, and the front-end uses `busy` to withhold acknowledges. The upper eighth of the address space never accepts a commit. A separate read port returns any array byte one cycle after its address is presented.

Back-pressure rules for the data stream:
- A byte transfers on a clock edge where both `wr_valid` and `wr_ready` are high.
- `wr_ready` is low in these cases: in idle, while the page is being copied in, and during the write cycle.
- `wr_ready` stays high from the end of the copy until a stop or a new address load.
- A byte presented in the same cycle as the stop is included in the commit.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `wr_ready` are low, and every array byte reads as the erased value 8'hFF.
- R2: After an address load outside a write cycle, `wr_ready` is low for exactly PAGE_BYTES cycles while the page is copied into the buffer, then goes high. Bytes transfer only while `wr_ready` is high.
- R3: Each transferred byte is stored at the in-page pointer. Only the low log2(PAGE_BYTES) pointer bits increment. Past the last byte of the page the pointer wraps to byte 0 of the same page, later bytes overwrite earlier ones, and nothing spills into the next page.
- R4: A stop after at least one byte rewrites the whole page. Written bytes take their last received values, and unwritten bytes keep their previous contents. The array is unchanged before the stop.
- R5: A committing stop raises `busy` in the following cycle and holds it for exactly max(WRITE_CYCLES, PAGE_BYTES) cycles, after which the block is idle.
- R6: A stop with no bytes since the address load changes no array byte and leaves `busy` low.
- R7: A sequence whose address has its three top bits all set (the upper eighth; 7000h–7FFFh at ADDR_W=15) changes no array byte and leaves `busy` low.
- R8: `rd_data` shows the array byte at `rd_addr` one cycle after the address is presented, for every address including the protected range.
- R9: While `busy` is high, address loads, data bytes and stops are ignored. `wr_ready` stays low, and the block is idle once `busy` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Strobe: load word address |
| addr | input | ADDR_W | Word address (page in upper bits, byte in page in lower bits) |
| wr_valid | input | 1 | Data byte valid |
| wr_ready | output | 1 | Block accepts a data byte |
| wr_data | input | 8 | Data byte |
| stop | input | 1 | Strobe: end of write sequence |
| busy | output | 1 | Internal write cycle in progress |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
The bench builds the block with ADDR_W=7, PAGE_BYTES=8 and WRITE_CYCLES=12. That gives a 128-byte array of sixteen pages, of which the last two are protected. At this size the bench can cover every page, every start offset and a set of lengths: empty, single byte, partial, exactly one page, and more than a page so the pointer wraps. After every sequence it reads back the whole page through the read port and compares it with an arithmetic model. Accesses during a write cycle and the unchanged array before a stop are covered by dedicated sequences.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRELOAD,
    ST_COLLECT,
    ST_COMMIT
  } pgwr_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ERASED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] fa_addr,
  output logic [DATA_W-1:0] fa_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Unregistered port used by the page copy-in sequencer.
  assign fa_data = mem[fa_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= ERASED;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFF_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) slot[i] <= '0;
    end else if (we) begin
      slot[waddr] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_BYTES = 64,
  parameter int BUSY_LEN = 64,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W = ADDR_W - OFF_W,
  localparam int CNT_W = $clog2(BUSY_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_valid,
  input  logic              stop,
  output logic              wr_ready,
  output logic              busy,
  output logic              preload_en,
  output logic              buf_we,
  output logic [OFF_W-1:0]  buf_waddr,
  output logic [OFF_W-1:0]  buf_raddr,
  output logic [ADDR_W-1:0] arr_fa_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BUSY_LEN - 1);

  pgwr_state_e      state_q;
  logic [PG_W-1:0]  page_q;
  logic [OFF_W-1:0] ptr_q;
  logic [OFF_W-1:0] idx_q;
  logic             got_q;
  logic             wact_q;
  logic [CNT_W-1:0] cnt_q;

  logic do_load;
  logic fire;
  logic locked;

  assign do_load = addr_load && (state_q != ST_COMMIT);
  assign fire    = wr_valid && wr_ready;
  assign locked  = &page_q[PG_W-1 -: 3];

  always_comb begin
    wr_ready    = (state_q == ST_COLLECT);
    busy        = (state_q == ST_COMMIT);
    preload_en  = (state_q == ST_PRELOAD);
    buf_we      = 1'b0;
    buf_waddr   = ptr_q;
    buf_raddr   = idx_q;
    arr_fa_addr = {page_q, idx_q};
    arr_we      = 1'b0;
    arr_waddr   = {page_q, idx_q};
    unique case (state_q)
      ST_PRELOAD: begin
        buf_we    = 1'b1;
        buf_waddr = idx_q;
      end
      ST_COLLECT: begin
        buf_we    = fire;
        buf_waddr = ptr_q;
      end
      ST_COMMIT: begin
        arr_we = wact_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      got_q   <= 1'b0;
      wact_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (do_load) begin
      state_q <= ST_PRELOAD;
      page_q  <= addr[ADDR_W-1:OFF_W];
      ptr_q   <= addr[OFF_W-1:0];
      idx_q   <= '0;
      got_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_PRELOAD: begin
          if (stop) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_OFF) state_q <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (fire) begin
            ptr_q <= ptr_q + 1'b1;
            got_q <= 1'b1;
          end
          if (stop) begin
            if ((got_q || fire) && !locked) begin
              state_q <= ST_COMMIT;
              idx_q   <= '0;
              wact_q  <= 1'b1;
              cnt_q   <= CNT_INIT;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_COMMIT: begin
          if (wact_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_OFF) wact_q <= 1'b0;
          end
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_BYTES = 64,
  parameter int WRITE_CYCLES = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              stop,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int BUSY_LEN = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;

  logic              preload_en;
  logic              buf_we;
  logic [OFF_W-1:0]  buf_waddr;
  logic [OFF_W-1:0]  buf_raddr;
  logic [7:0]        buf_wdata;
  logic [7:0]        buf_rdata;
  logic [ADDR_W-1:0] arr_fa_addr;
  logic [7:0]        arr_fa_data;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;

  pgwr_ctrl #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .BUSY_LEN   (BUSY_LEN)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_load   (addr_load),
    .addr        (addr),
    .wr_valid    (wr_valid),
    .stop        (stop),
    .wr_ready    (wr_ready),
    .busy        (busy),
    .preload_en  (preload_en),
    .buf_we      (buf_we),
    .buf_waddr   (buf_waddr),
    .buf_raddr   (buf_raddr),
    .arr_fa_addr (arr_fa_addr),
    .arr_we      (arr_we),
    .arr_waddr   (arr_waddr)
  );

  assign buf_wdata = preload_en ? arr_fa_data : wr_data;

  pgwr_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (8)
  ) buf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  pgwr_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (8),
    .ERASED (ERASED_BYTE)
  ) array_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (arr_we),
    .waddr   (arr_waddr),
    .wdata   (buf_rdata),
    .fa_addr (arr_fa_addr),
    .fa_data (arr_fa_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int ADDR_W = 12,
  parameter int BUSY_LEN = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic              stop,
  input logic              busy,
  input logic              wr_ready,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_waddr
);
  localparam int RUN_W = $clog2(BUSY_LEN + 2) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_ready_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  p_load_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !busy) |=> !wr_ready);

  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_W'(BUSY_LEN)));

  p_write_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_no_protected_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !(&arr_waddr[ADDR_W-1 -: 3]));
endmodule

bind pgwr_commit pgwr_commit_chk #(
  .ADDR_W   (ADDR_W),
  .BUSY_LEN (BUSY_LEN)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_load (addr_load),
  .stop      (stop),
  .busy      (busy),
  .wr_ready  (wr_ready),
  .arr_we    (arr_we),
  .arr_waddr (arr_waddr)
);

// File: tb/pgwr_commit_tb_top.sv
module pgwr_commit_tb_top;
  localparam int AW    = 7;
  localparam int PB    = 8;
  localparam int WC    = 12;
  localparam int BUSY  = (WC > PB) ? WC : PB;
  localparam int MEM   = 1 << AW;
  localparam int PAGES = MEM / PB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          stop = 1'b0;
  logic          busy;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [7:0] exp_mem [MEM];

  always #4 clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr(addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .stop(stop), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_cmp(input int a, input string req);
    @(negedge clk) rd_addr = AW'(a);
    @(negedge clk) chk(rd_data === exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
  endtask

  task automatic check_page(input int p, input string req);
    for (int i = 0; i < PB; i++) read_cmp(p * PB + i, req);
  endtask

  function automatic logic [7:0] pat(input int p, input int off, input int k, input int len);
    return 8'((p * 37 + off * 11 + k * 5 + len * 3 + 1) & 255);
  endfunction

  // One write sequence; poke drives loads, bytes and stops during the write cycle.
  task automatic do_txn(input int p, input int off, input int len, input bit poke);
    bit prot;
    int waits;
    int nb;
    int exp_busy;
    int first;
    logic [7:0] old_first;
    string req;
    prot  = (p * PB) >= (MEM / 8) * 7;
    first = p * PB + off;
    old_first = exp_mem[first];
    req = prot ? "R7" : (len == 0) ? "R6" : (len > PB) ? "R3" : "R4";
    @(negedge clk) begin addr_load = 1'b1; addr = AW'(first); end
    @(negedge clk) addr_load = 1'b0;
    chk(wr_ready == 1'b0, "R2", int'(wr_ready), 0);
    waits = 0;
    while (!wr_ready && waits < 100) begin
      @(negedge clk);
      waits++;
    end
    chk(waits == PB, "R2", waits, PB);
    for (int k = 0; k < len; k++) begin
      wr_valid = 1'b1;
      wr_data  = pat(p, off, k, len);
      if (!prot) exp_mem[p * PB + ((off + k) % PB)] = pat(p, off, k, len);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    if (len > 0) begin
      @(negedge clk) rd_addr = AW'(first);
      @(negedge clk) chk(rd_data === old_first, "R4", int'(rd_data), int'(old_first));
    end
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    nb = 0;
    while (busy && nb < 1000) begin
      nb++;
      chk(wr_ready == 1'b0, "R9", int'(wr_ready), 0);
      if (poke && nb <= 3) begin
        addr_load = 1'b1; addr = AW'(3 * PB + 1);
        wr_valid = 1'b1; wr_data = 8'h5A; stop = 1'b1;
      end else begin
        addr_load = 1'b0; wr_valid = 1'b0; stop = 1'b0;
      end
      @(negedge clk);
    end
    addr_load = 1'b0; wr_valid = 1'b0; stop = 1'b0;
    exp_busy = (len > 0 && !prot) ? BUSY : 0;
    chk(nb == exp_busy, (len == 0) ? "R6" : prot ? "R7" : "R5", nb, exp_busy);
    if (poke) begin
      repeat (PB + 2) @(negedge clk);
      chk(wr_ready == 1'b0 && busy == 1'b0, "R9", int'({busy, wr_ready}), 0);
      check_page(3, "R9");
    end
    check_page(p, req);
  endtask

  initial begin
    for (int i = 0; i < MEM; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(wr_ready == 1'b0, "R1", int'(wr_ready), 0);
    for (int i = 0; i < MEM; i += 9) read_cmp(i, "R1");

    // Poke test first so page 3 is still erased and its change would show.
    do_txn(1, 2, 3, 1'b1);

    for (int p = 0; p < PAGES; p++)
      for (int off = 0; off < PB; off++) begin
        do_txn(p, off, 0, 1'b0);
        do_txn(p, off, 1, 1'b0);
        do_txn(p, off, 3, 1'b0);
        do_txn(p, off, PB, 1'b0);
        do_txn(p, off, PB + 3, 1'b0);
      end

    // Final sweep of the whole array, protected range included.
    for (int i = 0; i < MEM; i++) read_cmp(i, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule